// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block divides its input clock by an integer between 1 and 256. Software sets it up through one 32-bit control word on a simple port made of a write strobe, write data and a read-back bus. The word holds an 8-bit divide code, a one-shot restart bit, a halt bit and a hardware-owned flag that shows a code change is still waiting to be applied. The divided clock leaves on `divClk`. The waiting flag is also driven on its own pin, so software can poll it.

A newly written code normally waits until the output period in progress has finished. Setting the restart bit in the same write applies the code one cycle later instead. Setting halt lets the current high phase finish, then holds the output low, so the upstream source can be switched. Clearing halt starts a whole new period from a zero count. Out of reset the block is halted with divide code 0.

Top module: `pclk_divider`

## Requirements
- R1: A divide code N in bits 7:0 gives an output period of exactly N+1 input clock cycles.
- R2: For N≥1 each period starts with a high phase of floor((N+1)/2) input cycles, and the rest of the period is low. The low phase is therefore equal to the high phase for even divisors and one cycle longer for odd divisors.
- R3: With code 0 the output follows the input clock, high during every input high phase. It is gated in only while the input is low.
- R4: A code written with bit 29 clear takes effect at the first period that starts after the current one ends. The current period keeps its old length.
- R5: A write with bit 29 set starts a new period with the written code on the next input cycle, from a zero count. Bit 29 always reads back as 0.
- R6: While bit 30 is 1 the output completes any high phase already under way and is then held low. Bit 30 reads back as written.
- R7: The write that clears bit 30 leaves the output low for that cycle. The next cycle begins a full period with the current code.
- R8: Bit 31 reads 1 from the write that changes the code until the cycle in which a period using that code begins, and it reads 0 in that cycle. Writes to bit 31 have no effect, and `pendFlag` mirrors bit 31.
- R9: After reset the word reads 0x4000_0000 (halted, code 0) and the output is low.
- R10: Bits 28:8 always read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Current control word and status |
| divClk | output | 1 | Divided clock output |
| pendFlag | output | 1 | Code change waiting to be applied |

## Verification
The bench builds the block with its default 8-bit code width, so the whole code space of 256 divisors is small enough to sweep. For every code it checks two full output periods sample by sample, along with the set and clear cycles of the pending flag. This puts passthrough, divide-by-2 and divide-by-256 in the same run. Directed sequences on top of the sweep compare a deferred update with a restarted one at the same point in a period, halt during a high phase, halt release with a pending code, and writes to the reserved and status bits.

// File: rtl/pclkdiv_pkg.sv
package pclkdiv_pkg;

  // Strobes and levels passed from the control word to the counter path
  typedef struct packed {
    logic restart;  // one-cycle pulse: start a new period now
    logic halt;     // level: freeze the output low
  } ctrlStb_t;

endpackage

// File: rtl/pclkdiv_ctrl.sv
module pclkdiv_ctrl #(
  parameter int CODE_W      = 8,
  parameter int REG_W       = 32,
  parameter int RESTART_POS = 29,
  parameter int HALT_POS    = 30,
  parameter int PEND_POS    = 31
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [REG_W-1:0]       wrData,
  input  logic                   loadStb,
  output pclkdiv_pkg::ctrlStb_t  stb,
  output logic [CODE_W-1:0]      codeVal,
  output logic                   pendFlag,
  output logic [REG_W-1:0]       rdData
);

  logic [CODE_W-1:0] codeReg;
  logic              haltReg;
  logic              restartReg;
  logic              pendReg;
  logic              codeChange;

  assign codeChange = wrEn && (wrData[CODE_W-1:0] != codeReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg    <= '0;
      haltReg    <= 1'b1;
      restartReg <= 1'b0;
      pendReg    <= 1'b0;
    end else begin
      restartReg <= wrEn & wrData[RESTART_POS];
      if (wrEn) begin
        codeReg <= wrData[CODE_W-1:0];
        haltReg <= wrData[HALT_POS];
      end
      if (codeChange)   pendReg <= 1'b1;
      else if (loadStb) pendReg <= 1'b0;
    end
  end

  always_comb begin
    rdData                = '0;
    rdData[CODE_W-1:0]    = codeReg;
    rdData[HALT_POS]      = haltReg;
    rdData[PEND_POS]      = pendReg;
  end

  assign stb.restart = restartReg;
  assign stb.halt    = haltReg;
  assign codeVal     = codeReg;
  assign pendFlag    = pendReg;

  // R8: a write that changes the code raises the pending flag
  assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    codeChange |=> pendFlag);

  // R8: a period start with no competing change clears the flag
  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !codeChange) |=> !pendFlag);

  // R5: the restart strobe only follows a write
  assert_restart_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |-> $past(wrEn));

endmodule

// File: rtl/pclkdiv_core.sv
module pclkdiv_core #(
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pclkdiv_pkg::ctrlStb_t stb,
  input  logic [CODE_W-1:0]     codeVal,
  output logic                  loadStb,
  output logic                  divClk
);

  localparam int               CW1  = CODE_W + 1;
  localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] cnt;       // position within current period
  logic [CODE_W-1:0] act;       // divide code in use
  logic              divQ;      // registered output for codes >= 1
  logic              frozen;    // output held low by halt
  logic              gateEn;    // passthrough enable, changes on low phase

  logic              holdFrozen;
  logic              startNow;
  logic [CODE_W-1:0] loadCode;
  logic [CODE_W-1:0] cntNext;
  logic [CW1-1:0]    halfLoad;
  logic              qNext;
  logic              freezeNow;

  always_comb begin
    holdFrozen = frozen & stb.halt;
    startNow   = frozen | stb.restart | (cnt == act);
    loadCode   = startNow ? codeVal : act;
    cntNext    = startNow ? '0 : cnt + ONE;
    halfLoad   = ({1'b0, loadCode} + {{CODE_W{1'b0}}, 1'b1}) >> 1;
    qNext      = (loadCode != '0) && ({1'b0, cntNext} < halfLoad);
    freezeNow  = stb.halt & ~qNext;
    loadStb    = ~holdFrozen & ~freezeNow & startNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      act    <= '0;
      divQ   <= 1'b0;
      frozen <= 1'b1;
    end else if (holdFrozen) begin
      frozen <= 1'b1;
    end else if (freezeNow) begin
      frozen <= 1'b1;
      cnt    <= '0;
      divQ   <= 1'b0;
    end else begin
      frozen <= 1'b0;
      cnt    <= cntNext;
      act    <= loadCode;
      divQ   <= qNext;
    end
  end

  // Passthrough gate is updated while the input clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= (act == '0) & ~frozen & ~stb.halt;
  end

  assign divClk = (clk & gateEn) | divQ;

  // R1: the count never passes the terminal value of the active code
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= act);

  // R2: every high phase begins at count zero
  assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divQ) |-> (cnt == '0));

  // R4: without restart the active code holds mid-period
  assert_defer_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && !stb.restart && (cnt != act)) |=> (act == $past(act)));

  // R6: frozen output stays low
  assert_frozen_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> !divQ);

  // R7: release begins a fresh period from zero
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !stb.halt) |=> (!frozen && (cnt == '0)));

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
  parameter int CODE_W      = 8,
  parameter int REG_W       = 32,
  parameter int RESTART_POS = 29,
  parameter int HALT_POS    = 30,
  parameter int PEND_POS    = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             divClk,
  output logic             pendFlag
);

  pclkdiv_pkg::ctrlStb_t stb;
  logic [CODE_W-1:0]     codeVal;
  logic                  loadStb;

  pclkdiv_ctrl #(
    .CODE_W(CODE_W), .REG_W(REG_W), .RESTART_POS(RESTART_POS),
    .HALT_POS(HALT_POS), .PEND_POS(PEND_POS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .loadStb(loadStb), .stb(stb), .codeVal(codeVal),
    .pendFlag(pendFlag), .rdData(rdData)
  );

  pclkdiv_core #(.CODE_W(CODE_W)) u_core (
    .clk(clk), .rstN(rstN), .stb(stb), .codeVal(codeVal),
    .loadStb(loadStb), .divClk(divClk)
  );

endmodule

// File: tb/pclk_divider_tb.sv
module pclk_divider_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        divClk;
  logic        pendFlag;

  int nVec = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  pclk_divider u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .divClk(divClk), .pendFlag(pendFlag)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    tick();
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic expOut(input string tag, input logic e);
    check(tag, {31'b0, divClk}, {31'b0, e});
  endtask

  task automatic expPend(input string tag, input logic e);
    check(tag, {31'b0, rdData[31]}, {31'b0, e});
    check(tag, {31'b0, pendFlag}, {31'b0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R9: reset value and quiet output
    check("R9 reset word", rdData, 32'h4000_0000);
    for (int i = 0; i < 4; i++) begin
      expOut("R9 output low after reset", 1'b0);
      tick();
    end

    // R1 R2 R3 R5 R8: sweep every code with restart
    for (int n = 0; n < 256; n++) begin
      int d;
      int half;
      int len;
      d = n + 1;
      half = d / 2;
      len = (n == 0) ? 4 : 2 * d;
      wr(32'h2000_0000 | n);
      check("R5 restart bit reads 0", {31'b0, rdData[29]}, 32'h0);
      expPend("R8 pending set on change", n != 0);
      tick();
      expPend("R8 pending clear at new period", 1'b0);
      for (int k = 0; k < len; k++) begin
        if (n == 0) begin
          if (k != 0) expOut("R3 passthrough", 1'b1);
        end else begin
          expOut("R1 R2 period and duty", ((k % d) < half));
        end
        tick();
      end
    end

    // R4: deferred update, code 5 then code 2 mid-period
    wr(32'h2000_0005);
    tick(); expOut("R4 old period", 1'b1);
    tick(); expOut("R4 old period", 1'b1);
    wr(32'h0000_0002);
    expOut("R4 old period", 1'b1); expPend("R8 set deferred", 1'b1);
    tick(); expOut("R4 old period", 1'b0);
    tick(); expOut("R4 old period", 1'b0);
    tick(); expOut("R4 old period", 1'b0); expPend("R8 still pending", 1'b1);
    tick(); expOut("R4 new period", 1'b1); expPend("R8 clear at load", 1'b0);
    tick(); expOut("R4 new period", 1'b0);
    tick(); expOut("R4 new period", 1'b0);
    tick(); expOut("R4 new period", 1'b1);

    // R5: immediate update at the same point
    wr(32'h2000_0005);
    tick(); expOut("R5 period", 1'b1);
    tick(); expOut("R5 period", 1'b1);
    wr(32'h2000_0002);
    expOut("R5 before restart", 1'b1); expPend("R8 set restart", 1'b1);
    check("R5 restart bit reads 0", {31'b0, rdData[29]}, 32'h0);
    tick(); expOut("R5 new period", 1'b1); expPend("R8 clear restart", 1'b0);
    tick(); expOut("R5 new period", 1'b0);
    tick(); expOut("R5 new period", 1'b0);
    tick(); expOut("R5 new period", 1'b1);

    // R6 R7: halt during a high phase, code 3
    wr(32'h2000_0003);
    tick(); expOut("R6 run", 1'b1);
    tick(); expOut("R6 run", 1'b1);
    tick(); expOut("R6 run", 1'b0);
    tick(); expOut("R6 run", 1'b0);
    wr(32'h4000_0003);
    expOut("R6 high phase completes", 1'b1);
    check("R6 halt bit reads back", {31'b0, rdData[30]}, 32'h1);
    tick(); expOut("R6 high phase completes", 1'b1);
    for (int i = 0; i < 20; i++) begin
      tick(); expOut("R6 held low", 1'b0);
    end
    wr(32'h4000_0004);
    expOut("R6 held low", 1'b0); expPend("R8 set while halted", 1'b1);
    for (int i = 0; i < 5; i++) begin
      tick(); expOut("R6 held low", 1'b0);
    end
    expPend("R8 pending while halted", 1'b1);
    wr(32'h0000_0004);
    expOut("R7 release cycle low", 1'b0);
    for (int k = 0; k < 10; k++) begin
      tick();
      expOut("R7 full period after release", ((k % 5) < 2));
      if (k == 0) expPend("R8 clear on release", 1'b0);
    end

    // R8 R10: status and reserved bits ignore writes
    wr(32'h9FFF_FF04);
    check("R8 R10 ignored bits", rdData, 32'h0000_0004);
    wr(32'h1FFF_FF06);
    check("R10 reserved read 0", {1'b0, rdData[30:0]}, 32'h0000_0006);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule